// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Character FIFO

This block walks the rows of a key matrix (or sensor array) one at a time. For each row it drives a scan pattern on four scan lines and samples eight active-low return lines. A key closure counts only after it has been seen on two successive visits to its row. The accepted closure becomes one byte: the row, the column and the state of the shift and control inputs at that moment. The byte is written into an eight-entry first-in first-out buffer. The buffer raises an interrupt request for as long as it holds at least one byte.

A host reads the buffer through a small synchronous read port, gated by an active-low chip select and an active-low read strobe. One address bit picks between the data byte (which pops the buffer) and a status byte (entry count, full flag, overrun flag). The scan lines carry either a binary row number over eight rows or a one-hot pattern over four rows. A separate strobed-capture mode ignores the matrix and stores the raw return-line byte each time the control input falls.

Top module: `kbs_matrix_scanner`

## Requirements
- R1: In binary scan mode (`scan_decoded`=0) `scan_out` shows the row number 0..7 in bits 2:0 with bit 3 at 0. In one-hot mode (`scan_decoded`=1) `scan_out` has bit `row` set for rows 0..3. Each row is held for DWELL clock cycles and the rows advance in ascending order with wraparound. After reset and after any change of scan mode the scan starts at row 0.
- R2: A return line at 0 means a closed key. A closure is accepted only if it is present on two consecutive visits of the same row. A closure seen on a single visit produces no byte.
- R3: An accepted key byte is {ctrl_key, shift_key, row[2:0], column[2:0]}: bit 7 control, bit 6 shift, bits 5:3 row, bits 2:0 the index of the return line. The shift and control inputs are taken in the cycle the key is accepted.
- R4: A key held closed produces exactly one byte. Once the key has been seen open on a visit of its row, pressing it again produces a new byte.
- R5: When several keys of one row become accepted on the same visit, the lowest column is stored first. One further byte is stored on each later visit of that row.
- R6: A data read (`addr0`=0) returns the oldest byte and removes it, so bytes come out in the order they were stored. A data read of an empty buffer returns 8'h00 and changes nothing.
- R7: A status read (`addr0`=1) returns bit 7 overrun, bit 6 full and bits 3:0 the entry count, with bits 5:4 at 0. It removes nothing, and it clears the overrun flag.
- R8: A byte arriving while the buffer holds 8 entries is dropped and sets the overrun flag. The stored contents and the count stay unchanged.
- R9: `irq` is 1 exactly while the buffer holds at least one byte. It falls after the read that empties the buffer.
- R10: In strobed mode (`strobe_mode`=1) each 1-to-0 transition of `ctrl_key` stores the `ret_n` byte unmodified. Key closures on the matrix store nothing.
- R11: A read takes effect only in a cycle where both `cs_n` and `rd_n` are 0. With `cs_n` at 1, `rdata` and the buffer are unchanged.
- R12: `rdata` is registered: it shows the read result from the clock edge that ends the read cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one cycle per access |
| addr0 | input | 1 | 0 selects the data byte, 1 selects the status byte |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request: buffer not empty |
| scan_decoded | input | 1 | 0 binary scan over 8 rows, 1 one-hot scan over 4 rows |
| strobe_mode | input | 1 | 1 selects strobed capture instead of matrix scanning |
| scan_out | output | 4 | Scan lines |
| ret_n | input | 8 | Return lines, active low |
| shift_key | input | 1 | Shift key state, active high |
| ctrl_key | input | 1 | Control key state, also the capture strobe in strobed mode |

## Verification
The hardest situation to create from the ports is a closure that lasts exactly one visit of its row. The bench's matrix model derives the return lines from the live scan lines. It waits for the first cycle of the target row, holds the key for exactly DWELL cycles and releases it before the row comes round again. The overrun path needs nine bytes with no reads in between. The bench produces them in strobed mode, where each byte is chosen arithmetically. The same bytes then give a known order to compare against on the way out.

// File: rtl/kbs_pkg.sv
// Shared constants and the key byte layout for the matrix keyboard scanner.
// Assumes a fixed 8x8 matrix: the stored byte holds a 3-bit row and column.
package kbs_pkg;

    localparam int ROW_W    = 3;
    localparam int COL_W    = 3;
    localparam int ROWS     = 1 << ROW_W;
    localparam int COLS     = 1 << COL_W;
    localparam int DEC_ROWS = 4;
    localparam int SCAN_W   = 4;

    typedef logic [7:0] kbyte_t;

    // Pack control, shift, row and column into one stored byte.
    function automatic kbyte_t make_code(input logic ctrl, input logic shift,
                                         input logic [ROW_W-1:0] row,
                                         input logic [COL_W-1:0] col);
        return {ctrl, shift, row, col};
    endfunction

endpackage

// File: rtl/kbs_scan_timer.sv
// Row sequencer: holds each row for DWELL cycles, then advances with wrap.
// In one-hot mode only rows 0..3 are visited. A change of mode restarts at
// row 0, and no sample is taken in the cycle the change is seen.
// Assumes DWELL >= 2.
module kbs_scan_timer
    import kbs_pkg::*;
#(
    parameter int DWELL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decoded,
    output logic              sample,
    output logic [ROW_W-1:0]  row,
    output logic [SCAN_W-1:0] scan_out
);

    localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;

    logic [DW-1:0]    dcnt;
    logic             mode_q;
    logic [ROW_W-1:0] last_row;

    // Pick the last row visited for the current scan style.
    always_comb begin
        last_row = decoded ? ROW_W'(DEC_ROWS - 1) : ROW_W'(ROWS - 1);
    end

    assign sample = (dcnt == DW'(DWELL - 1)) && (decoded == mode_q);

    // Advance the dwell counter and the row, restarting on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt   <= '0;
            row    <= '0;
            mode_q <= 1'b0;
        end else if (decoded != mode_q) begin
            mode_q <= decoded;
            dcnt   <= '0;
            row    <= '0;
        end else if (sample) begin
            dcnt <= '0;
            row  <= (row == last_row) ? '0 : row + 1'b1;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // Drive the scan lines as a binary row number or as a one-hot pattern.
    always_comb begin
        if (decoded) scan_out = SCAN_W'(1) << row[1:0];
        else         scan_out = SCAN_W'(row);
    end

endmodule

// File: rtl/kbs_debounce.sv
// Per-key debounce and acceptance. For every row it keeps the closures seen
// on the previous visit and the keys already reported. A key is reported
// once it is closed on two visits in a row, at most one key per visit with
// the lowest column first. It is forgotten when seen open again.
module kbs_debounce
    import kbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sample,
    input  logic [ROW_W-1:0] row,
    input  logic [COLS-1:0]  closed,
    input  logic             shift,
    input  logic             ctrl,
    output logic             push,
    output kbyte_t           code
);

    logic [COLS-1:0]  prev_q [ROWS];
    logic [COLS-1:0]  acc_q  [ROWS];
    logic [COLS-1:0]  fresh;
    logic [COLS-1:0]  pick;
    logic [COL_W-1:0] idx;

    // Find stable, unreported closures in the current row; choose the lowest.
    always_comb begin
        fresh = closed & prev_q[row] & ~acc_q[row];
        idx   = '0;
        pick  = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (fresh[i]) begin
                idx  = COL_W'(i);
                pick = COLS'(1) << i;
            end
        end
    end

    assign push = enable && sample && (|fresh);
    assign code = make_code(ctrl, shift, row, idx);

    // Record this visit's closures and update the reported-key set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                prev_q[r] <= '0;
                acc_q[r]  <= '0;
            end
        end else if (enable && sample) begin
            prev_q[row] <= closed;
            acc_q[row]  <= (acc_q[row] & closed) | pick;
        end
    end

endmodule

// File: rtl/kbs_fifo.sv
// Character buffer: DEPTH bytes, first in first out. A push while full is
// dropped and sets a sticky overrun flag, which ovr_clr clears. A pop of
// an empty buffer is ignored. Assumes DEPTH >= 2.
module kbs_fifo
    import kbs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  kbyte_t                     din,
    input  logic                       pop,
    input  logic                       ovr_clr,
    output kbyte_t                     head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       overrun
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    kbyte_t        mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    // Move pointers and count; latch overrun on a dropped byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count   <= count + CW'(push_ok) - CW'(pop_ok);
            overrun <= (overrun && !ovr_clr) || (push && full);
        end
    end

endmodule

// File: rtl/kbs_matrix_scanner.sv
// Top level: matrix scan, debounce and strobed capture feeding a character
// buffer, with a synchronous read port (data byte or status byte) and an
// interrupt request while the buffer is not empty. Assumes one rd_n low
// cycle per access and synchronous inputs.
module kbs_matrix_scanner
    import kbs_pkg::*;
#(
    parameter int DWELL = 4,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         addr0,
    output logic [7:0]   rdata,
    output logic         irq,
    input  logic         scan_decoded,
    input  logic         strobe_mode,
    output logic [3:0]   scan_out,
    input  logic [7:0]   ret_n,
    input  logic         shift_key,
    input  logic         ctrl_key
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             sample;
    logic [ROW_W-1:0] row;
    logic             db_push;
    kbyte_t           db_code;
    logic             ctrl_q;
    logic             strobe_fall;
    logic             push_req;
    kbyte_t           push_data;
    logic             data_rd;
    logic             stat_rd;
    kbyte_t           fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full;
    logic             fifo_ovr;
    kbyte_t           status;

    kbs_scan_timer #(.DWELL(DWELL)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .decoded  (scan_decoded),
        .sample   (sample),
        .row      (row),
        .scan_out (scan_out)
    );

    kbs_debounce u_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!strobe_mode),
        .sample (sample),
        .row    (row),
        .closed (~ret_n),
        .shift  (shift_key),
        .ctrl   (ctrl_key),
        .push   (db_push),
        .code   (db_code)
    );

    // Remember the previous control input to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 1'b1;
        else        ctrl_q <= ctrl_key;
    end

    assign strobe_fall = strobe_mode && ctrl_q && !ctrl_key;
    assign push_req    = strobe_mode ? strobe_fall : db_push;
    assign push_data   = strobe_mode ? ret_n : db_code;
    assign data_rd     = !cs_n && !rd_n && !addr0;
    assign stat_rd     = !cs_n && !rd_n && addr0;

    kbs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_req),
        .din     (push_data),
        .pop     (data_rd),
        .ovr_clr (stat_rd),
        .head    (fifo_head),
        .count   (fifo_count),
        .full    (fifo_full),
        .overrun (fifo_ovr)
    );

    // Assemble the status byte from the buffer flags and count.
    always_comb begin
        status            = '0;
        status[7]         = fifo_ovr;
        status[6]         = fifo_full;
        status[CNT_W-1:0] = fifo_count;
    end

    // Register the read result for the selected port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (data_rd) begin
            rdata <= (fifo_count != '0) ? fifo_head : '0;
        end else if (stat_rd) begin
            rdata <= status;
        end
    end

    assign irq = (fifo_count != '0);

endmodule

// File: rtl/kbs_matrix_scanner_chk.sv
// Property checker for the matrix keyboard scanner, bound to the top level.
// It observes the scan lines, buffer state, pushes and reads.
module kbs_matrix_scanner_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scan_decoded,
    input logic [3:0]                 scan_out,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       full,
    input logic                       overrun,
    input logic                       push,
    input logic                       data_rd,
    input logic                       stat_rd
);

    localparam int CW = $clog2(DEPTH + 1);

    // R1: one-hot scan drives exactly one line once the mode has settled
    a_r1_decoded_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        scan_decoded && $stable(scan_decoded) |-> $countones(scan_out) == 1);

    // R8: the entry count never exceeds the depth
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R8: a byte arriving when full sets overrun
    a_r8_overrun_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push && full |=> overrun);

    // R8: a dropped byte leaves the count unchanged
    a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !data_rd |=> $stable(count));

    // R7: a status read removes nothing
    a_r7_status_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !push |=> $stable(count));

    // R9: a stored byte raises the interrupt request
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        push && !full |=> irq);

    // R9: the read that empties the buffer drops the interrupt request
    a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && count == CW'(1) && !push |=> !irq);

endmodule

bind kbs_matrix_scanner kbs_matrix_scanner_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_decoded (scan_decoded),
    .scan_out     (scan_out),
    .irq          (irq),
    .count        (fifo_count),
    .full         (fifo_full),
    .overrun      (fifo_ovr),
    .push         (push_req),
    .data_rd      (data_rd),
    .stat_rd      (stat_rd)
);

// File: tb/kbs_matrix_scanner_tb.sv
// Bench: a matrix model answers the live scan lines. Sweeps all keys in both
// scan styles, then checks the single-visit glitch, same-row priority,
// strobed capture, buffer order, overrun and chip select.
module kbs_matrix_scanner_tb;

    localparam int DWELL = 4;
    localparam int DEPTH = 8;
    localparam int FRAME = 8 * DWELL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       addr0 = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    logic       scan_decoded = 1'b0;
    logic       strobe_mode = 1'b0;
    logic [3:0] scan_out;
    logic [7:0] ret_n;
    logic       shift_key = 1'b0;
    logic       ctrl_key = 1'b0;

    logic [63:0] pressed = '0;
    logic        use_sdata = 1'b0;
    logic [7:0]  sdata = '0;
    logic [2:0]  cur_row;
    logic        row_valid;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    kbs_matrix_scanner #(.DWELL(DWELL), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .addr0(addr0),
        .rdata(rdata), .irq(irq), .scan_decoded(scan_decoded),
        .strobe_mode(strobe_mode), .scan_out(scan_out), .ret_n(ret_n),
        .shift_key(shift_key), .ctrl_key(ctrl_key)
    );

    // Matrix model: return lines show the pressed keys of the scanned row.
    always_comb begin
        cur_row   = 3'd0;
        row_valid = 1'b1;
        if (scan_decoded) begin
            row_valid = (scan_out != 4'd0);
            for (int i = 0; i < 4; i++) if (scan_out[i]) cur_row = 3'(i);
        end else begin
            cur_row = scan_out[2:0];
        end
        if (use_sdata)      ret_n = sdata;
        else if (row_valid) ret_n = ~pressed[{cur_row, 3'b000} +: 8];
        else                ret_n = 8'hFF;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic a, input logic csn, output logic [7:0] v);
        @(negedge clk);
        cs_n = csn; rd_n = 1'b0; addr0 = a;
        @(negedge clk);
        v = rdata;
        cs_n = 1'b1; rd_n = 1'b1; addr0 = 1'b0;
    endtask

    function automatic logic [3:0] scode(input int r);
        return scan_decoded ? 4'(1 << r) : 4'(r);
    endfunction

    task automatic wait_row(input int r);
        while (scan_out == scode(r)) @(negedge clk);
        while (scan_out != scode(r)) @(negedge clk);
    endtask

    // Press one key, read its byte, hold to confirm no repeat, release.
    task automatic key_test(input int r, input int c, input logic shf, input logic ctl);
        logic [7:0] v;
        shift_key = shf; ctrl_key = ctl;
        pressed[r*8 + c] = 1'b1;
        tick(3 * FRAME);
        chk("R9 irq after key", 32'(irq), 32'd1);
        do_read(1'b1, 1'b0, v);
        chk("R7 status one entry", 32'(v), 32'h01);
        do_read(1'b0, 1'b0, v);
        chk("R3 key byte", 32'(v), 32'({ctl, shf, 3'(r), 3'(c)}));
        chk("R9 irq after emptying", 32'(irq), 32'd0);
        tick(3 * FRAME);
        do_read(1'b1, 1'b0, v);
        chk("R4 held key no repeat", 32'(v), 32'h00);
        pressed[r*8 + c] = 1'b0;
        tick(3 * FRAME);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R9 irq at reset", 32'(irq), 32'd0);
        chk("R1 scan at reset", 32'(scan_out), 32'd0);
        chk("R12 rdata at reset", 32'(rdata), 32'd0);
        do_read(1'b1, 1'b0, v);
        chk("R7 status at reset", 32'(v), 32'h00);
        do_read(1'b0, 1'b0, v);
        chk("R6 empty data read", 32'(v), 32'h00);

        // R1 binary scan sequence
        wait_row(0);
        for (int i = 0; i < 2 * FRAME; i++) begin
            chk("R1 binary scan", 32'(scan_out), 32'((i / DWELL) % 8));
            @(negedge clk);
        end

        // R1 one-hot scan sequence
        scan_decoded = 1'b1;
        tick(2);
        wait_row(0);
        for (int i = 0; i < 2 * 4 * DWELL; i++) begin
            chk("R1 one-hot scan", 32'(scan_out), 32'(1 << ((i / DWELL) % 4)));
            @(negedge clk);
        end

        // R3 R4 key sweep, one-hot scan rows 0..3
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                key_test(r, c, 1'(c & 1), 1'(r & 1));

        // R3 R4 key sweep, binary scan, all 64 keys
        scan_decoded = 1'b0;
        tick(2);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                key_test(r, c, 1'((r + c) & 1), 1'((c >> 2) & 1));

        // R4 the same key pressed a second time
        key_test(6, 1, 1'b0, 1'b0);
        key_test(6, 1, 1'b1, 1'b1);
        shift_key = 1'b0; ctrl_key = 1'b0;

        // R2 closure present on a single visit only
        wait_row(5);
        pressed[5*8 + 3] = 1'b1;
        tick(DWELL);
        pressed[5*8 + 3] = 1'b0;
        tick(3 * FRAME);
        do_read(1'b1, 1'b0, v);
        chk("R2 glitch rejected", 32'(v), 32'h00);

        // R5 two keys of one row: lowest column first
        pressed[4*8 + 5] = 1'b1;
        pressed[4*8 + 2] = 1'b1;
        tick(4 * FRAME);
        do_read(1'b1, 1'b0, v);
        chk("R5 two entries", 32'(v), 32'h02);
        do_read(1'b0, 1'b0, v);
        chk("R5 first lower column", 32'(v), 32'h22);
        do_read(1'b0, 1'b0, v);
        chk("R5 then higher column", 32'(v), 32'h25);
        pressed = '0;
        tick(3 * FRAME);

        // R10 strobed mode ignores the matrix
        ctrl_key = 1'b1;
        tick(1);
        strobe_mode = 1'b1;
        pressed[2*8 + 2] = 1'b1;
        tick(3 * FRAME);
        do_read(1'b1, 1'b0, v);
        chk("R10 no key bytes in strobed mode", 32'(v), 32'h00);
        pressed = '0;

        // R10 one strobe, then R11 read without chip select
        use_sdata = 1'b1;
        sdata = 8'hE1;
        @(negedge clk); ctrl_key = 1'b0;
        @(negedge clk); ctrl_key = 1'b1;
        tick(2);
        do_read(1'b0, 1'b1, v);
        chk("R11 rdata unchanged without select", 32'(v), 32'h00);
        do_read(1'b1, 1'b0, v);
        chk("R11 buffer unchanged without select", 32'(v), 32'h01);
        do_read(1'b0, 1'b0, v);
        chk("R10 strobed byte raw", 32'(v), 32'hE1);

        // R8 nine strobes into an eight-entry buffer
        for (int i = 0; i < 9; i++) begin
            sdata = 8'(8'h11 * i + 8'h07);
            @(negedge clk); ctrl_key = 1'b0;
            @(negedge clk); ctrl_key = 1'b1;
        end
        use_sdata = 1'b0;
        tick(2);
        do_read(1'b1, 1'b0, v);
        chk("R8 full with overrun", 32'(v), 32'hC8);
        do_read(1'b1, 1'b0, v);
        chk("R7 overrun cleared by status read", 32'(v), 32'h48);
        for (int i = 0; i < 8; i++) begin
            chk("R9 irq while data waits", 32'(irq), 32'd1);
            do_read(1'b0, 1'b0, v);
            chk("R6 order", 32'(v), 32'(8'(8'h11 * i + 8'h07)));
        end
        chk("R9 irq after last read", 32'(irq), 32'd0);
        do_read(1'b0, 1'b0, v);
        chk("R6 empty read after drain", 32'(v), 32'h00);
        do_read(1'b1, 1'b0, v);
        chk("R7 status after drain", 32'(v), 32'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule